// File: doc/BRIEF.md
# Five-Stage In-Order Interlocked Pipeline

This block is a compact in-order execution pipeline. Instructions travel through five stages: fetch, decode, register read, execute and register write. There is no data memory and there are no branches. Each operand comes either from an eight-entry register file or from an immediate field carried in the instruction word. Instructions arrive on a valid/ready stream. One word is taken on every cycle in which both `in_valid` and `in_ready` are high.

No bypass network exists between stages. When an instruction reads a register that the instruction just ahead of it writes, the dependent instruction waits in the register-read stage for a fixed two cycles. During that wait, bubbles enter execute and the fetch and decode stages hold. The register file passes a value that is being written in the write stage through to a same-cycle read. A dependency two instructions apart therefore costs nothing.

Every instruction that completes raises a one-cycle retire strobe. The strobe carries the destination register, the result and the number of the cycle in which the write took place. A testbench or a timing model can use these to compare the retire cycles against the analytical rule.

Top module: `pipe5_core`

## Requirements
- R1: Synchronous active-low reset clears all eight registers to zero and flushes every stage to a bubble. No retire strobe follows until an instruction is taken. The cycle counter reads 1 in the first cycle after reset is released, so an instruction taken in that cycle retires with cycle number 5.
- R2: An instruction that has no dependency on its predecessor retires four cycles after it was taken. It never retires earlier than one cycle after its predecessor.
- R3: If an instruction reads the register written by the instruction immediately before it, it retires three cycles after that predecessor. `in_ready` is low for exactly two cycles for each such dependency, and the execute stage receives bubbles during those cycles.
- R4: Four instructions are taken back to back from cycle 1: r1:=7, r2:=r1+2, r3:=r1+3 and r4:=r1+4. They retire in cycles 5, 8, 9 and 10 with values 7, 9, 10 and 11.
- R5: A value in the write stage is visible to the register-read stage in the same cycle. A dependency at distance two therefore causes no stall and still reads the new value.
- R6: The instruction word is opcode[15:13], destination[12:10], first source[9:7] and field[6:0]. The second source register is field[2:0]. The immediate is field zero-extended to 16 bits. The opcodes are 0 copy (d=s), 1 load-immediate (d=imm), 2 add (d=s+t), 3 subtract (d=s-t), 4 and, 5 or, 6 xor, and 7 add-immediate (d=s+imm). All arithmetic is modulo 2^16.
- R7: Each instruction taken produces exactly one single-cycle retire strobe. The strobe carries its destination and result, and the strobes come in program order.
- R8: While a stall lasts, the word held in decode does not change and the input is not taken. Idle cycles on the input (valid low) produce no retire.
- R9: Load-immediate reads no register. It never stalls, even when its first-source field names the predecessor's destination.
- R10: A dependency through the second source register of a register-register operation stalls in the same way as one through the first source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Pipeline can take a word this cycle |
| in_instr | input | 16 | Instruction word |
| ret_valid | output | 1 | One-cycle retire strobe |
| ret_dest | output | 3 | Destination register of the retiring instruction |
| ret_data | output | 16 | Result written back |
| ret_cycle | output | 32 | Cycle number of the write-back |

## Verification
The hardest case to reach from the ports is a dependency whose producer is already two stages ahead. That case depends on the same-cycle pass-through in the register file and not on the interlock. It only arises when an unrelated instruction sits between producer and consumer while the stream runs without gaps. The directed programs place such instructions immediately after a stalled pair and next to a load-immediate whose source field deliberately names the producer. The bench also feeds programs with idle gaps. A bench model derives each instruction's register-read cycle from its measured acceptance cycle, so the retire cycle and the stall count are predicted for every spacing.

// File: rtl/pipe5_pkg.sv
// pipe5_pkg: shared widths, opcode encoding and stage payload types for the
// five-stage interlocked pipeline. Assumes a 16-bit word with fixed fields.
package pipe5_pkg;
    localparam int INSTR_W  = 16;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int RIDX_W   = $clog2(NUM_REGS);
    localparam int OPC_W    = 3;
    localparam int FLD_W    = INSTR_W - OPC_W - 2 * RIDX_W;
    localparam int CYC_W    = 32;

    typedef enum logic [OPC_W-1:0] {
        OP_MOVR = 3'd0,
        OP_MOVI = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_ADDI = 3'd7
    } opc_e;

    // decoded instruction held in the register-read stage
    typedef struct packed {
        logic              vld;
        opc_e              op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic              use_rs;
        logic              use_rt;
        logic [DATA_W-1:0] imm;
    } dec_t;

    // operands held in the execute stage
    typedef struct packed {
        logic              vld;
        opc_e              op;
        logic [RIDX_W-1:0] rd;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } exe_t;

    // result held in the write stage
    typedef struct packed {
        logic              vld;
        logic [RIDX_W-1:0] rd;
        logic [DATA_W-1:0] res;
    } wbk_t;
endpackage

// File: rtl/p5_decode.sv
// p5_decode: splits a raw instruction word into fields and marks which
// register sources the opcode really reads. Purely combinational.
module p5_decode
    import pipe5_pkg::*;
(
    input  logic               vld,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RD_LSB  = OPC_LSB - RIDX_W;
    localparam int RS_LSB  = RD_LSB - RIDX_W;

    // field extraction and source-usage decode
    always_comb begin
        dec.vld    = vld;
        dec.op     = opc_e'(instr[INSTR_W-1:OPC_LSB]);
        dec.rd     = instr[RD_LSB +: RIDX_W];
        dec.rs     = instr[RS_LSB +: RIDX_W];
        dec.rt     = instr[RIDX_W-1:0];
        dec.imm    = DATA_W'(instr[FLD_W-1:0]);
        dec.use_rs = (dec.op != OP_MOVI);
        dec.use_rt = (dec.op == OP_ADD) || (dec.op == OP_SUB) ||
                     (dec.op == OP_AND) || (dec.op == OP_OR)  ||
                     (dec.op == OP_XOR);
    end
endmodule

// File: rtl/p5_regfile.sv
// p5_regfile: register file with one write and two read ports. A write in
// progress is passed through to a same-cycle read of the same index.
// Assumes synchronous active-low reset clears every entry.
module p5_regfile
    import pipe5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // storage update and reset clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read ports with write pass-through
    always_comb begin
        rd1 = (we && waddr == ra1) ? wdata : mem[ra1];
        rd2 = (we && waddr == ra2) ? wdata : mem[ra2];
    end

    // R5
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/p5_hazard.sv
// p5_hazard: interlock for a read-after-write on the instruction one stage
// ahead. Holds the register-read stage for STALL_CYCLES cycles once a
// match is seen; assumes the upstream stages freeze while stall is high.
module p5_hazard
    import pipe5_pkg::*;
#(
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_vld,
    input  logic              rr_use_rs,
    input  logic              rr_use_rt,
    input  logic [RIDX_W-1:0] rr_rs,
    input  logic [RIDX_W-1:0] rr_rt,
    input  logic              ex_vld,
    input  logic [RIDX_W-1:0] ex_rd,
    output logic              stall
);
    localparam int CNT_W = $clog2(STALL_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;
    logic             match;

    // dependency compare against the producer in execute
    always_comb begin
        match = rr_vld && ex_vld &&
                ((rr_use_rs && rr_rs == ex_rd) || (rr_use_rt && rr_rt == ex_rd));
        stall = match || (remain_q != '0);
    end

    // remaining stall cycles after the first
    always_ff @(posedge clk) begin
        if (!rst_n)                         remain_q <= '0;
        else if (match && remain_q == '0)   remain_q <= CNT_W'(STALL_CYCLES - 1);
        else if (remain_q != '0)            remain_q <= remain_q - 1'b1;
    end

    // R3
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q < CNT_W'(STALL_CYCLES));

    generate
        if (STALL_CYCLES >= 2) begin : g_hold
            // R3
            stall_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (match && remain_q == '0) |=> stall);
        end
    endgenerate
endmodule

// File: rtl/p5_alu.sv
// p5_alu: combinational result for every opcode; operand b is either the
// second register or the zero-extended immediate, chosen upstream.
module p5_alu
    import pipe5_pkg::*;
(
    input  opc_e              op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    // opcode select
    always_comb begin
        unique case (op)
            OP_MOVR: res = opa;
            OP_MOVI: res = opb;
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_ADDI: res = opa + opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/pipe5_core.sv
// pipe5_core: five-stage in-order pipeline (fetch, decode, register read,
// execute, write) with no bypass. A dependency on the previous instruction
// holds it in register read for STALL_CYCLES cycles. Assumes a
// valid/ready instruction stream and synchronous active-low reset.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int STALL_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               ret_valid,
    output logic [RIDX_W-1:0]  ret_dest,
    output logic [DATA_W-1:0]  ret_data,
    output logic [CYC_W-1:0]   ret_cycle
);
    logic               stall;
    logic [CYC_W-1:0]   cyc_q;
    logic               id_vld;
    logic [INSTR_W-1:0] id_instr;
    dec_t               id_dec;
    dec_t               rr_q;
    exe_t               ex_q;
    wbk_t               wb_q;
    logic [DATA_W-1:0]  rf_a;
    logic [DATA_W-1:0]  rf_b;
    logic [DATA_W-1:0]  alu_res;

    assign in_ready = !stall;

    // cycle counter, 1 in the first cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= CYC_W'(1);
        else        cyc_q <= cyc_q + 1'b1;
    end

    // fetch: capture an accepted word into decode, hold during a stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_vld   <= 1'b0;
            id_instr <= '0;
        end else if (!stall) begin
            id_vld   <= in_valid;
            id_instr <= in_instr;
        end
    end

    p5_decode u_dec (
        .vld   (id_vld),
        .instr (id_instr),
        .dec   (id_dec)
    );

    // decode to register read, hold during a stall
    always_ff @(posedge clk) begin
        if (!rst_n)      rr_q <= '0;
        else if (!stall) rr_q <= id_dec;
    end

    p5_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_q.vld),
        .waddr (wb_q.rd),
        .wdata (wb_q.res),
        .ra1   (rr_q.rs),
        .ra2   (rr_q.rt),
        .rd1   (rf_a),
        .rd2   (rf_b)
    );

    p5_hazard #(.STALL_CYCLES(STALL_CYCLES)) u_haz (
        .clk       (clk),
        .rst_n     (rst_n),
        .rr_vld    (rr_q.vld),
        .rr_use_rs (rr_q.use_rs),
        .rr_use_rt (rr_q.use_rt),
        .rr_rs     (rr_q.rs),
        .rr_rt     (rr_q.rt),
        .ex_vld    (ex_q.vld),
        .ex_rd     (ex_q.rd),
        .stall     (stall)
    );

    // register read to execute, bubble while stalled
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            ex_q <= '0;
        end else begin
            ex_q.vld <= rr_q.vld;
            ex_q.op  <= rr_q.op;
            ex_q.rd  <= rr_q.rd;
            ex_q.opa <= rr_q.use_rs ? rf_a : '0;
            ex_q.opb <= rr_q.use_rt ? rf_b : rr_q.imm;
        end
    end

    p5_alu u_alu (
        .op  (ex_q.op),
        .opa (ex_q.opa),
        .opb (ex_q.opb),
        .res (alu_res)
    );

    // execute to write stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q.vld <= ex_q.vld;
            wb_q.rd  <= ex_q.rd;
            wb_q.res <= alu_res;
        end
    end

    // retire report
    always_comb begin
        ret_valid = wb_q.vld;
        ret_dest  = wb_q.rd;
        ret_data  = wb_q.res;
        ret_cycle = cyc_q;
    end

    // R3
    bubble_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ex_q.vld);

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(id_instr) && $stable(id_vld)));

    // R2
    rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && rr_q.vld) |=> ex_q.vld);

    // R7
    retire_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(ex_q.vld));
endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_instr = '0;
    logic        ret_valid;
    logic [2:0]  ret_dest;
    logic [15:0] ret_data;
    logic [31:0] ret_cycle;

    int n_cmp = 0;
    int n_bad = 0;
    int tb_cyc = 1;
    int n_ret = 0;
    int n_low = 0;
    int prog_n = 0;
    logic [15:0] prog [32];
    int          fc   [32];
    int          rc   [64];
    logic [2:0]  rdst [64];
    logic [15:0] rval [64];
    logic [15:0] mdl  [8];

    pipe5_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_instr  (in_instr),
        .ret_valid (ret_valid),
        .ret_dest  (ret_dest),
        .ret_data  (ret_data),
        .ret_cycle (ret_cycle)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= 1;
        else        tb_cyc <= tb_cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ret_valid) begin
                if (n_ret < 64) begin
                    rc[n_ret]   = int'(ret_cycle);
                    rdst[n_ret] = ret_dest;
                    rval[n_ret] = ret_data;
                end
                n_ret = n_ret + 1;
            end
            if (!in_ready) n_low = n_low + 1;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int fld);
        return {3'(op), 3'(rd), 3'(rs), 7'(fld)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_instr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_ret = 0;
        n_low = 0;
        prog_n = 0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
    endtask

    task automatic add(input logic [15:0] w);
        prog[prog_n] = w;
        prog_n++;
    endtask

    task automatic push(input int idx);
        in_valid = 1'b1;
        in_instr = prog[idx];
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        fc[idx] = tb_cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic feed(input int gap);
        for (int i = 0; i < prog_n; i++) begin
            push(i);
            repeat (gap) @(negedge clk);
        end
        repeat (14) @(negedge clk);
    endtask

    // bench model derived from the requirements: register-read cycle,
    // two-cycle interlock on an adjacent dependency, write four after fetch
    task automatic check_prog(input string tag);
        int rr_prev = 0;
        int rr;
        int stalls = 0;
        logic [2:0] prd = '0;
        for (int i = 0; i < prog_n; i++) begin
            int op = int'(prog[i][15:13]);
            logic [2:0] rd = prog[i][12:10];
            logic [2:0] rs = prog[i][9:7];
            logic [2:0] rt = prog[i][2:0];
            logic [15:0] imm = {9'd0, prog[i][6:0]};
            bit urs = (op != 1);
            bit urt = (op >= 2 && op <= 6);
            logic [15:0] a = urs ? mdl[rs] : 16'd0;
            logic [15:0] b = urt ? mdl[rt] : imm;
            logic [15:0] y;
            bit dep;
            case (op)
                0: y = a;
                1: y = b;
                2: y = a + b;
                3: y = a - b;
                4: y = a & b;
                5: y = a | b;
                6: y = a ^ b;
                default: y = a + b;
            endcase
            dep = (i > 0) && ((urs && rs == prd) || (urt && rt == prd));
            rr = fc[i] + 2;
            if (i > 0 && rr < rr_prev + 1) rr = rr_prev + 1;
            if (dep && rr == rr_prev + 1) begin
                rr = rr + 2;
                stalls++;
            end
            if (i < n_ret) begin
                chk(rc[i] == rr + 2, $sformatf("%s R2 R3 retire cycle of #%0d", tag, i), rc[i], rr + 2);
                chk(rdst[i] == rd, $sformatf("%s R7 destination of #%0d", tag, i), rdst[i], rd);
                chk(rval[i] == y, $sformatf("%s R6 result of #%0d", tag, i), rval[i], y);
            end
            mdl[rd] = y;
            prd = rd;
            rr_prev = rr;
        end
        chk(n_ret == prog_n, $sformatf("%s R7 retire count", tag), n_ret, prog_n);
        chk(n_low == 2 * stalls, $sformatf("%s R3 in_ready low cycles", tag), n_low, 2 * stalls);
    endtask

    task automatic t_reset();
        do_reset();
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(ret_valid == 1'b0, "R1 no retire after reset", ret_valid, 0);
        repeat (6) @(negedge clk);
        chk(n_ret == 0, "R1 idle retire count", n_ret, 0);
        add(enc(1, 3, 0, 55));
        add(enc(1, 5, 0, 99));
        feed(0);
        check_prog("reset-pre");
        do_reset();
        add(enc(0, 1, 3, 0));
        add(enc(7, 2, 5, 0));
        feed(0);
        chk(n_ret > 0 && rc[0] == 5, "R1 first write-back cycle", rc[0], 5);
        chk(rval[0] == 16'd0, "R1 r3 cleared by reset", rval[0], 0);
        chk(rval[1] == 16'd0, "R1 r5 cleared by reset", rval[1], 0);
        check_prog("reset-post");
    endtask

    task automatic t_example();
        do_reset();
        add(enc(1, 1, 0, 7));
        add(enc(7, 2, 1, 2));
        add(enc(7, 3, 1, 3));
        add(enc(7, 4, 1, 4));
        feed(0);
        chk(rc[0] == 5,  "R4 cycle #0", rc[0], 5);
        chk(rc[1] == 8,  "R4 cycle #1", rc[1], 8);
        chk(rc[2] == 9,  "R4 cycle #2", rc[2], 9);
        chk(rc[3] == 10, "R4 cycle #3", rc[3], 10);
        chk(rval[3] == 16'd11, "R4 value #3", rval[3], 11);
        check_prog("example");
    endtask

    task automatic t_ops();
        do_reset();
        add(enc(1, 1, 0, 100));
        add(enc(1, 2, 0, 37));
        add(enc(1, 5, 0, 9));
        add(enc(2, 4, 1, 2));
        add(enc(3, 6, 2, 1));
        add(enc(4, 7, 1, 2));
        add(enc(5, 3, 1, 2));
        add(enc(6, 0, 1, 2));
        add(enc(0, 5, 1, 0));
        add(enc(7, 6, 2, 127));
        add(enc(3, 7, 0, 1));
        feed(0);
        check_prog("ops R2 R6");
    endtask

    task automatic t_hazard();
        do_reset();
        add(enc(1, 1, 0, 3));
        add(enc(2, 2, 0, 1));
        add(enc(1, 1, 2, 20));
        add(enc(7, 3, 2, 1));
        add(enc(1, 6, 0, 4));
        add(enc(7, 6, 6, 1));
        add(enc(6, 7, 3, 6));
        feed(0);
        chk(rc[1] == rc[0] + 3, "R10 second-source stall", rc[1], rc[0] + 3);
        chk(rc[2] == rc[1] + 1, "R9 load-immediate no stall", rc[2], rc[1] + 1);
        chk(rc[3] == rc[2] + 1, "R5 distance-two no stall", rc[3], rc[2] + 1);
        chk(rval[3] == 16'd4, "R5 distance-two value", rval[3], 4);
        chk(rc[5] == rc[4] + 3, "R3 adjacent first-source stall", rc[5], rc[4] + 3);
        check_prog("hazard R3 R5 R9 R10");
    endtask

    task automatic t_gaps();
        do_reset();
        add(enc(1, 1, 0, 5));
        add(enc(7, 2, 1, 1));
        add(enc(7, 3, 2, 1));
        add(enc(2, 4, 3, 1));
        feed(1);
        chk(n_low == 0, "R8 no stall with gaps", n_low, 0);
        check_prog("gap1 R8");
        do_reset();
        add(enc(1, 1, 0, 8));
        add(enc(7, 1, 1, 1));
        add(enc(7, 1, 1, 1));
        add(enc(0, 2, 1, 0));
        feed(2);
        chk(rval[3] == 16'd10, "R8 chain through gaps", rval[3], 10);
        check_prog("gap2 R8");
    endtask

    initial begin
        t_reset();
        t_example();
        t_ops();
        t_hazard();
        t_gaps();
        summary();
        $finish;
    end
endmodule